// File: doc/BRIEF.md
# Clock-Fanout Enable Register Slave (two-wire serial)

This block is the control side of an eighteen-output clock fanout buffer. It listens on a two-wire serial bus (I2C signalling, standard-mode rate), answers only to its fixed 7-bit device address, and keeps three 8-bit enable registers. Each register bit switches one buffered clock output on or off. A separate active-low output-enable pin overrides every register bit and floats all outputs.

All traffic is block-structured. A write carries two leading bytes that the block acknowledges and then discards, a command byte and a count byte. The bytes after them fill the registers in ascending order from register 0. A read starts with a count byte (value 0x09) and then returns the registers in ascending order. No transfer can select a register at random. Both bus lines are oversampled on a fast system clock. The block pulls SDA low through an open-drain style output and never drives it high.

Top module: `clkfan_i2c_regs`

## Requirements
- R1: After reset, every bit of `clk_en_o` is 1 and `sda_drive_low` is 0. A read issued before any write returns 0x09 and then 0xFF, 0xFF, 0xFF.
- R2: Only the address byte 0xD2 (write) or 0xD3 (read), i.e. device address 7'b1101001, gets an acknowledge. Any other address byte is left unacknowledged. The block then ignores all traffic, and changes no register, until the next START.
- R3: In a write, the first two bytes after the address are acknowledged and change nothing. Data bytes 1, 2 and 3 load registers 0, 1 and 2 in that order, and each data byte is acknowledged.
- R4: Write data bytes after the third are acknowledged and leave all registers unchanged.
- R5: A read returns the count byte 0x09 first, then registers 0, 1 and 2 in order, then 0x00 for every further byte. Bits go out MSB first.
- R6: Register 0 bit k drives `clk_en_o[k]`, and register 1 bit k drives `clk_en_o[8+k]`. Register 2 bit 6 drives `clk_en_o[16]` and bit 7 drives `clk_en_o[17]`. Register 2 bits 5..0 are stored and read back but drive no output. A 1 bit enables its output.
- R7: When the master answers a read byte with NACK (SDA high in the acknowledge slot), the block releases SDA. It drives nothing more until the next START.
- R8: A START seen at any point, including in the middle of a byte, releases SDA and restarts address reception. The following write fills from register 0 again.
- R9: While `oe_n_i` is 0, `pad_drive_o` is all zeros whatever the registers hold. While it is 1, `pad_drive_o` equals `clk_en_o`.
- R10: `sda_drive_low` changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus (wired-AND level) |
| sda_drive_low | output | 1 | 1 pulls SDA low, 0 releases it |
| oe_n_i | input | 1 | Active-low enable for all clock outputs |
| clk_en_o | output | 18 | Per-output enable taken from the registers |
| pad_drive_o | output | 18 | Final per-output drive enable after the override |

## Verification
A wrong bit counter or state would show on the bus at once. The acknowledge would land in the wrong SCL slot, or returned data would shift by a bit position within the same byte. A stale byte index does not show in the acknowledge pattern. It shows as data landing in the wrong register, which `clk_en_o` exposes one system clock after the data byte ends, or as a shifted read sequence on the next read. Errors in the NACK and mid-byte START paths leave SDA held low in a slot that should be released, so the master's next sampled bit is wrong.

// File: rtl/clkfan_pkg.sv
package clkfan_pkg;

    localparam int BYTE_W = 8;
    localparam int IDX_W  = 4;

    // Synchronised bus view plus the events derived from it
    typedef struct packed {
        logic scl;
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_evt_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_RX_DONE,
        ST_ACK,
        ST_TX,
        ST_MACK,
        ST_MACK_WAIT,
        ST_IGNORE
    } slv_state_t;

    // Number of 8-bit registers needed to hold one enable per output
    function automatic int regs_for(input int outputs);
        return (outputs + BYTE_W - 1) / BYTE_W;
    endfunction

    // Saturating increment of the byte position
    function automatic logic [IDX_W-1:0] idx_next(input logic [IDX_W-1:0] v);
        return (v == {IDX_W{1'b1}}) ? v : v + 1'b1;
    endfunction

endpackage

// File: rtl/clkfan_bus_sync.sv
module clkfan_bus_sync
    import clkfan_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output bus_evt_t evt
);

    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_q;
    logic              sda_q;

    // Idle bus level is high on both lines, so reset to 1 to avoid a false START
    always_ff @(posedge clk) begin
        if (rst) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
            scl_q    <= scl_pipe[STAGES-1];
            sda_q    <= sda_pipe[STAGES-1];
        end
    end

    always_comb begin
        evt.scl      = scl_pipe[STAGES-1];
        evt.sda      = sda_pipe[STAGES-1];
        evt.scl_rise = evt.scl & ~scl_q;
        evt.scl_fall = ~evt.scl & scl_q;
        evt.start    = evt.scl & scl_q & sda_q & ~evt.sda;
        evt.stop     = evt.scl & scl_q & ~sda_q & evt.sda;
    end

endmodule

// File: rtl/clkfan_slave_fsm.sv
module clkfan_slave_fsm
    import clkfan_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h69,
    parameter int         NUM_REGS = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_evt_t          evt,
    input  logic [BYTE_W-1:0] rd_data,
    output logic [IDX_W-1:0]  rd_idx,
    output logic              wr_stb,
    output logic [IDX_W-1:0]  wr_sel,
    output logic [BYTE_W-1:0] wr_data,
    output logic              sda_low
);

    // Write stream: position 0 = command, 1 = count, 2.. = registers
    localparam logic [IDX_W-1:0] FIRST_DATA = IDX_W'(2);
    localparam logic [IDX_W-1:0] REG_LIMIT  = IDX_W'(NUM_REGS);

    slv_state_t        state;
    logic [2:0]        bit_cnt;
    logic [BYTE_W-1:0] rx_sh;
    logic [BYTE_W-1:0] tx_sh;
    logic [IDX_W-1:0]  idx;
    logic              addr_phase;
    logic              rd_mode;
    logic [IDX_W-1:0]  data_off;
    logic              data_hit;

    assign rd_idx   = idx;
    assign data_off = idx - FIRST_DATA;
    assign data_hit = (idx >= FIRST_DATA) && (data_off < REG_LIMIT);

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            bit_cnt    <= '0;
            rx_sh      <= '0;
            tx_sh      <= '0;
            idx        <= '0;
            addr_phase <= 1'b0;
            rd_mode    <= 1'b0;
            sda_low    <= 1'b0;
            wr_stb     <= 1'b0;
            wr_sel     <= '0;
            wr_data    <= '0;
        end else begin
            wr_stb <= 1'b0;
            if (evt.start) begin
                state      <= ST_RX;
                bit_cnt    <= '0;
                addr_phase <= 1'b1;
                idx        <= '0;
                sda_low    <= 1'b0;
            end else if (evt.stop) begin
                state   <= ST_IDLE;
                idx     <= '0;
                sda_low <= 1'b0;
            end else begin
                unique case (state)
                    ST_RX: begin
                        if (evt.scl_rise) begin
                            rx_sh   <= {rx_sh[BYTE_W-2:0], evt.sda};
                            bit_cnt <= bit_cnt + 3'd1;
                            if (bit_cnt == 3'd7) begin
                                state <= ST_RX_DONE;
                            end
                        end
                    end
                    ST_RX_DONE: begin
                        if (evt.scl_fall) begin
                            if (addr_phase) begin
                                if (rx_sh[BYTE_W-1:1] == DEV_ADDR) begin
                                    rd_mode <= rx_sh[0];
                                    sda_low <= 1'b1;
                                    state   <= ST_ACK;
                                end else begin
                                    state <= ST_IGNORE;
                                end
                            end else begin
                                if (data_hit) begin
                                    wr_stb  <= 1'b1;
                                    wr_sel  <= data_off;
                                    wr_data <= rx_sh;
                                end
                                idx     <= idx_next(idx);
                                sda_low <= 1'b1;
                                state   <= ST_ACK;
                            end
                        end
                    end
                    ST_ACK: begin
                        if (evt.scl_fall) begin
                            bit_cnt    <= '0;
                            addr_phase <= 1'b0;
                            if (addr_phase && rd_mode) begin
                                tx_sh   <= rd_data;
                                sda_low <= ~rd_data[BYTE_W-1];
                                state   <= ST_TX;
                            end else begin
                                sda_low <= 1'b0;
                                state   <= ST_RX;
                            end
                        end
                    end
                    ST_TX: begin
                        if (evt.scl_fall) begin
                            bit_cnt <= bit_cnt + 3'd1;
                            if (bit_cnt == 3'd7) begin
                                sda_low <= 1'b0;
                                idx     <= idx_next(idx);
                                state   <= ST_MACK;
                            end else begin
                                tx_sh   <= {tx_sh[BYTE_W-2:0], 1'b0};
                                sda_low <= ~tx_sh[BYTE_W-2];
                            end
                        end
                    end
                    ST_MACK: begin
                        if (evt.scl_rise) begin
                            state <= evt.sda ? ST_IGNORE : ST_MACK_WAIT;
                        end
                    end
                    ST_MACK_WAIT: begin
                        if (evt.scl_fall) begin
                            tx_sh   <= rd_data;
                            sda_low <= ~rd_data[BYTE_W-1];
                            bit_cnt <= '0;
                            state   <= ST_TX;
                        end
                    end
                    default: begin
                        state <= state;
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/clkfan_regbank.sv
module clkfan_regbank
    import clkfan_pkg::*;
#(
    parameter int          NUM_OUT    = 18,
    parameter logic [7:0]  COUNT_INIT = 8'h09
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_stb,
    input  logic [IDX_W-1:0]   wr_sel,
    input  logic [BYTE_W-1:0]  wr_data,
    input  logic [IDX_W-1:0]   rd_idx,
    output logic [BYTE_W-1:0]  rd_data,
    output logic [NUM_OUT-1:0] clk_en
);

    localparam int NUM_REGS = regs_for(NUM_OUT);
    localparam int FULL     = NUM_OUT / BYTE_W;
    localparam int TAIL     = NUM_OUT - FULL * BYTE_W;

    logic [NUM_REGS-1:0][BYTE_W-1:0] regs;

    always_ff @(posedge clk) begin
        if (rst) begin
            regs <= '1;
        end else begin
            for (int r = 0; r < NUM_REGS; r++) begin
                if (wr_stb && (wr_sel == IDX_W'(r))) begin
                    regs[r] <= wr_data;
                end
            end
        end
    end

    // Read stream: position 0 = count byte, 1.. = registers, beyond = zero
    always_comb begin
        rd_data = '0;
        if (rd_idx == '0) begin
            rd_data = COUNT_INIT;
        end else begin
            for (int r = 0; r < NUM_REGS; r++) begin
                if (rd_idx == IDX_W'(r + 1)) begin
                    rd_data = regs[r];
                end
            end
        end
    end

    // Full registers map bit for bit; a partial last register uses its top bits
    for (genvar k = 0; k < NUM_OUT; k++) begin : g_map
        if (k < FULL * BYTE_W) begin : g_full
            assign clk_en[k] = regs[k / BYTE_W][k % BYTE_W];
        end else begin : g_tail
            assign clk_en[k] = regs[NUM_REGS-1][BYTE_W - TAIL + (k - FULL * BYTE_W)];
        end
    end

endmodule

// File: rtl/clkfan_i2c_regs.sv
module clkfan_i2c_regs
    import clkfan_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h69,
    parameter int         NUM_OUT     = 18,
    parameter logic [7:0] COUNT_INIT  = 8'h09,
    parameter int         SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               scl_i,
    input  logic               sda_i,
    output logic               sda_drive_low,
    input  logic               oe_n_i,
    output logic [NUM_OUT-1:0] clk_en_o,
    output logic [NUM_OUT-1:0] pad_drive_o
);

    localparam int NUM_REGS = regs_for(NUM_OUT);

    bus_evt_t          evt;
    logic              scl_sync;
    logic              start_seen;
    logic [IDX_W-1:0]  rd_idx;
    logic [BYTE_W-1:0] rd_data;
    logic              wr_stb;
    logic [IDX_W-1:0]  wr_sel;
    logic [BYTE_W-1:0] wr_data;

    clkfan_bus_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .evt   (evt)
    );

    clkfan_slave_fsm #(
        .DEV_ADDR (DEV_ADDR),
        .NUM_REGS (NUM_REGS)
    ) u_fsm (
        .clk     (clk),
        .rst     (rst),
        .evt     (evt),
        .rd_data (rd_data),
        .rd_idx  (rd_idx),
        .wr_stb  (wr_stb),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .sda_low (sda_drive_low)
    );

    clkfan_regbank #(
        .NUM_OUT    (NUM_OUT),
        .COUNT_INIT (COUNT_INIT)
    ) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_stb  (wr_stb),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .rd_idx  (rd_idx),
        .rd_data (rd_data),
        .clk_en  (clk_en_o)
    );

    assign scl_sync    = evt.scl;
    assign start_seen  = evt.start;
    assign pad_drive_o = oe_n_i ? clk_en_o : '0;

endmodule

// File: rtl/clkfan_i2c_regs_chk.sv
module clkfan_i2c_regs_chk
    import clkfan_pkg::*;
#(
    parameter int NUM_OUT  = 18,
    parameter int NUM_REGS = 3
) (
    input logic               clk,
    input logic               rst,
    input logic               scl_sync,
    input logic               start_seen,
    input logic               sda_drive_low,
    input logic               wr_stb,
    input logic [IDX_W-1:0]   wr_sel,
    input logic               oe_n_i,
    input logic [NUM_OUT-1:0] clk_en_o,
    input logic [NUM_OUT-1:0] pad_drive_o
);

    AST_SDA_MOVES_WITH_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_drive_low) |-> !scl_sync); // R10

    AST_ENABLES_CHANGE_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
        !$stable(clk_en_o) |-> $past(wr_stb)); // R3

    AST_WRITE_TARGET_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        wr_stb |-> (wr_sel < IDX_W'(NUM_REGS))); // R4

    AST_START_FREES_SDA: assert property (@(posedge clk) disable iff (rst)
        $past(start_seen) |-> !sda_drive_low); // R8

    AST_OE_OVERRIDE: assert property (@(posedge clk) disable iff (rst)
        !oe_n_i |-> (pad_drive_o == '0)); // R9

    AST_PAD_WITHIN_ENABLES: assert property (@(posedge clk) disable iff (rst)
        (pad_drive_o & ~clk_en_o) == '0); // R6

endmodule

bind clkfan_i2c_regs clkfan_i2c_regs_chk #(
    .NUM_OUT  (NUM_OUT),
    .NUM_REGS (NUM_REGS)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .scl_sync      (scl_sync),
    .start_seen    (start_seen),
    .sda_drive_low (sda_drive_low),
    .wr_stb        (wr_stb),
    .wr_sel        (wr_sel),
    .oe_n_i        (oe_n_i),
    .clk_en_o      (clk_en_o),
    .pad_drive_o   (pad_drive_o)
);

// File: tb/tb_clkfan_i2c_regs.sv
module tb_clkfan_i2c_regs;

    localparam int Q = 10;   // quarter SCL period in system clocks

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic        oe_n = 1'b1;
    logic        sda_drive_low;
    logic [17:0] clk_en_o;
    logic [17:0] pad_drive_o;
    wire         sda_bus = sda_m & ~sda_drive_low;

    int checks = 0;
    int errors = 0;
    logic [7:0] mreg [0:2];
    logic [7:0] rb [0:7];

    always #10 clk = ~clk;

    clkfan_i2c_regs dut (
        .clk           (clk),
        .rst           (rst),
        .scl_i         (scl_m),
        .sda_i         (sda_bus),
        .sda_drive_low (sda_drive_low),
        .oe_n_i        (oe_n),
        .clk_en_o      (clk_en_o),
        .pad_drive_o   (pad_drive_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    function automatic logic [17:0] exp_en();
        return {mreg[2][7:6], mreg[1], mreg[0]};
    endfunction

    // R10 monitor: SDA drive may only move while the raw SCL is low
    logic sda_prev = 1'b0;
    always @(negedge clk) begin
        if (!rst && (sda_drive_low !== sda_prev)) begin
            checks++;
            if (scl_m) begin
                errors++;
                $display("FAIL R10 sda drive moved with SCL high act=1 exp=0");
            end
        end
        sda_prev <= sda_drive_low;
    end

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wait_clk(Q);
        scl_m = 1'b1; wait_clk(Q);
        sda_m = 1'b0; wait_clk(Q);
        scl_m = 1'b0; wait_clk(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wait_clk(Q);
        scl_m = 1'b1; wait_clk(Q);
        sda_m = 1'b1; wait_clk(2 * Q);
    endtask

    task automatic put_bit(input logic b);
        sda_m = b;    wait_clk(Q);
        scl_m = 1'b1; wait_clk(2 * Q);
        scl_m = 1'b0; wait_clk(Q);
    endtask

    task automatic get_bit(output logic b);
        sda_m = 1'b1; wait_clk(Q);
        scl_m = 1'b1; wait_clk(Q);
        b = sda_bus;  wait_clk(Q);
        scl_m = 1'b0; wait_clk(Q);
    endtask

    task automatic send_byte(input logic [7:0] v, output logic acked);
        logic b;
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        get_bit(b);
        acked = ~b;
    endtask

    task automatic recv_byte(output logic [7:0] v, input logic give_ack);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            v[i] = b;
        end
        put_bit(~give_ack);
    endtask

    // Block write: address, command, count, then n data bytes
    task automatic block_write(input string req, input int n,
                               input logic [7:0] d0, input logic [7:0] d1,
                               input logic [7:0] d2, input logic [7:0] d3,
                               input logic [7:0] d4);
        logic a;
        logic [7:0] d [0:4];
        d[0] = d0; d[1] = d1; d[2] = d2; d[3] = d3; d[4] = d4;
        bus_start();
        send_byte(8'hD2, a); check({req, " addr ack"}, a, 1);
        send_byte(8'h5C, a); check({req, " command ack"}, a, 1);
        send_byte(8'h07, a); check({req, " count ack"}, a, 1);
        for (int i = 0; i < n; i++) begin
            send_byte(d[i], a);
            check({req, " data ack"}, a, 1);
            if (i < 3) mreg[i] = d[i];
        end
        bus_stop();
    endtask

    // Block read of n bytes (count byte included), NACK on the last one
    task automatic block_read(input string req, input int n);
        logic a;
        bus_start();
        send_byte(8'hD3, a); check({req, " read addr ack"}, a, 1);
        for (int i = 0; i < n; i++) recv_byte(rb[i], i != n - 1);
        bus_stop();
    endtask

    task automatic t_reset();
        check("R1 enables after reset", clk_en_o, 18'h3FFFF);
        check("R1 sda released after reset", sda_drive_low, 0);
        check("R9 pads follow enables", pad_drive_o, 18'h3FFFF);
    endtask

    task automatic t_read_defaults();
        block_read("R1", 4);
        check("R1 count byte", rb[0], 8'h09);
        check("R1 reg0 default", rb[1], 8'hFF);
        check("R1 reg1 default", rb[2], 8'hFF);
        check("R1 reg2 default", rb[3], 8'hFF);
    endtask

    task automatic t_dummy_only();
        block_write("R3 dummies", 0, 0, 0, 0, 0, 0);
        check("R3 command and count change nothing", clk_en_o, 18'h3FFFF);
    endtask

    task automatic t_write_basic();
        block_write("R3", 3, 8'hA5, 8'h3C, 8'h40, 8'h00, 8'h00);
        check("R3 R6 enable map after write", clk_en_o, exp_en());
        check("R6 out16 from reg2 bit6", clk_en_o[16], 1);
        check("R6 out17 from reg2 bit7", clk_en_o[17], 0);
    endtask

    task automatic t_read_back();
        block_read("R5", 6);
        check("R5 count first", rb[0], 8'h09);
        check("R5 reg0", rb[1], mreg[0]);
        check("R5 reg1", rb[2], mreg[1]);
        check("R6 reg2 reserved bits stored", rb[3], mreg[2]);
        check("R5 past last reg is zero", rb[4], 8'h00);
        check("R5 second byte past last reg is zero", rb[5], 8'h00);
    endtask

    task automatic t_wrong_addr();
        logic a;
        bus_start();
        send_byte(8'hA0, a); check("R2 foreign address not acked", a, 0);
        send_byte(8'h11, a); check("R2 ignored byte not acked", a, 0);
        send_byte(8'h22, a);
        send_byte(8'h00, a);
        bus_stop();
        check("R2 registers untouched", clk_en_o, exp_en());
        bus_start();
        send_byte(8'hD0, a); check("R2 near-miss address not acked", a, 0);
        bus_stop();
    endtask

    task automatic t_overrun();
        block_write("R4", 5, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55);
        check("R4 extra bytes discarded", clk_en_o, exp_en());
        block_read("R4", 5);
        check("R4 reg0 readback", rb[1], 8'h11);
        check("R4 reg2 readback", rb[3], 8'h33);
        check("R4 R5 beyond reads zero", rb[4], 8'h00);
    endtask

    task automatic t_read_nack();
        logic a;
        logic [7:0] v;
        bus_start();
        send_byte(8'hD3, a); check("R7 read addr ack", a, 1);
        recv_byte(v, 1'b0);
        check("R7 count before nack", v, 8'h09);
        recv_byte(v, 1'b0);
        check("R7 bus released after nack", v, 8'hFF);
        check("R7 sda not driven", sda_drive_low, 0);
        bus_stop();
    endtask

    task automatic t_restart();
        logic a;
        bus_start();
        send_byte(8'hD2, a); check("R8 first addr ack", a, 1);
        put_bit(1'b1); put_bit(1'b0); put_bit(1'b1); put_bit(1'b1);
        bus_start();
        send_byte(8'hD2, a); check("R8 addr after restart ack", a, 1);
        send_byte(8'h01, a);
        send_byte(8'h02, a);
        send_byte(8'h5A, a); check("R8 data ack", a, 1);
        mreg[0] = 8'h5A;
        bus_stop();
        check("R8 index restarted at reg0", clk_en_o, exp_en());
    endtask

    task automatic t_oe();
        oe_n = 1'b0; wait_clk(2);
        check("R9 pads floated", pad_drive_o, 18'h0);
        check("R9 enables kept", clk_en_o, exp_en());
        oe_n = 1'b1; wait_clk(2);
        check("R9 pads restored", pad_drive_o, exp_en());
    endtask

    initial begin
        for (int i = 0; i < 3; i++) mreg[i] = 8'hFF;
        wait_clk(5);
        rst = 1'b0;
        wait_clk(5);
        t_reset();
        t_read_defaults();
        t_dummy_only();
        t_write_basic();
        t_read_back();
        t_wrong_addr();
        t_overrun();
        t_read_nack();
        t_restart();
        t_oe();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog all-requirements act=timeout exp=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule